// File: doc/BRIEF.md
# USB Transmit Endpoint Control

This block is the control and status logic for one transmit endpoint of a USB controller. It holds an 8-bit control register that the CPU reads and writes. The register sets automatic packet-ready marking, the direction of a shared FIFO, DMA request enabling and the DMA interrupt mode. It also holds the data toggle and accepts two self-clearing command bits: one that gates a toggle write and one that forces a toggle.

The FIFO side-band reports each write together with the number of bytes the FIFO now holds, and it reports the ACK for a transmitted packet. From these events and from the software controls the block keeps the packet-ready flag and the data toggle. It also issues a one-cycle FIFO flush pulse, a DMA request level and a one-cycle endpoint interrupt. The DMA engine signals the end of each packet and the end of the whole transfer.

Top module: `usb_tx_ep_ctrl`

## Requirements
- R1: After reset every register field is 0, and packet-ready, data toggle, flush, DMA request, interrupt and the direction output are all 0.
- R2: The read value packs the fields as bit 7 auto-set, bit 5 direction (1 = transmit), bit 4 DMA enable, bit 2 DMA interrupt mode, bit 1 toggle-write enable and bit 0 data toggle. Bits 6 and 3 always read 0.
- R3: With auto-set at 1 and transmit direction, a FIFO write that reports a byte level equal to the nonzero maximum packet size sets packet-ready at the next clock edge. Any other level leaves packet-ready unchanged.
- R4: With auto-set at 0, FIFO writes never set packet-ready. A software set pulse always sets it at the next edge.
- R5: A register write loads bit 0 into the data toggle only when bit 1 is 1 in the same write. The toggle-write enable reads 1 for one cycle after such a write and then returns to 0 by itself.
- R6: A write with bit 3 set while packet-ready is 1 flips the toggle, clears packet-ready and gives one flush pulse. The same write while packet-ready is 0 changes neither the toggle nor the flush output.
- R7: An ACK while packet-ready is 1 flips the toggle, clears packet-ready and gives a one-cycle flush pulse at the same edge. An ACK while packet-ready is 0 has no effect.
- R8: The DMA request is high exactly when DMA is enabled, packet-ready is 0 and the endpoint is in transmit direction.
- R9: With DMA enabled, the interrupt pulses for one cycle after each DMA packet end when the mode bit is 0, or after each transfer end when it is 1. The other event is ignored, and no interrupt is raised while DMA is disabled.
- R10: The DMA interrupt mode never changes while DMA enable is 1. A write that clears DMA enable applies its mode value one cycle later. A write that keeps DMA enable set leaves the mode unchanged.
- R11: With a shared FIFO, direction 0 forces the DMA request low and blocks auto-set.
- R12: When a write sets the toggle-write enable and a toggle event happens in the same cycle, the written toggle value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| txrdy_set | input | 1 | Software packet-ready set pulse |
| fifo_wr | input | 1 | FIFO write event |
| fifo_level | input | CNT_W | Bytes held after this FIFO write |
| max_pkt | input | CNT_W | Programmed maximum packet size |
| tx_ack | input | 1 | ACK received for the transmitted packet |
| dma_pkt_done | input | 1 | DMA finished one packet |
| dma_xfer_done | input | 1 | DMA finished the whole transfer |
| txrdy | output | 1 | Packet-ready flag |
| data_toggle | output | 1 | Current data toggle |
| fifo_flush | output | 1 | One-cycle packet release or flush pulse |
| dma_req | output | 1 | DMA request |
| ep_irq | output | 1 | One-cycle endpoint interrupt |
| dir_tx | output | 1 | Endpoint is in transmit direction |

## Verification
The bench sweeps every pair of maximum size and FIFO level in a 4-bit configuration. A comparator that is off by one, or that fires below the maximum, would set packet-ready on the wrong write. It forces a toggle with and without a pending packet. A design that ignored the packet-ready gate would flip the toggle and flush data that was never queued. It clears DMA enable and the interrupt mode in one write and then reads the mode back in the next two cycles. A design without the ordering rule would drop the mode at once. It also combines a toggle load with a forced toggle, where a wrong priority leaves the opposite toggle value.

// File: rtl/usb_txep_pkg.sv
package usb_txep_pkg;
  localparam int B_AUTO   = 7;
  localparam int B_RSV    = 6;
  localparam int B_MODE   = 5;
  localparam int B_DMAEN  = 4;
  localparam int B_FORCE  = 3;
  localparam int B_DMAMOD = 2;
  localparam int B_DTWE   = 1;
  localparam int B_DT     = 0;

  // true when a FIFO write completed a packet of the programmed size
  function automatic logic pkt_full(input logic [15:0] level, input logic [15:0] max_sz);
    return (max_sz != 16'd0) && (level == max_sz);
  endfunction

  // next data toggle: explicit load beats any toggle event
  function automatic logic dt_next(input logic load, input logic wval,
                                   input logic tog, input logic cur);
    if (load) return wval;
    if (tog) return ~cur;
    return cur;
  endfunction
endpackage

// File: rtl/txep_cfg_reg.sv
module txep_cfg_reg
  import usb_txep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic       autoset,
  output logic       mode,
  output logic       dmaen,
  output logic       dmamod,
  output logic       dtwe,
  output logic       dt_load,
  output logic       dt_wval,
  output logic       force_req
);
  logic mod_pend;
  logic mod_pend_val;
  logic wr_rsv_unused;

  assign wr_rsv_unused = reg_wdata[B_RSV];
  assign dt_load   = reg_wr & reg_wdata[B_DTWE];
  assign dt_wval   = reg_wdata[B_DT];
  assign force_req = reg_wr & reg_wdata[B_FORCE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      autoset      <= 1'b0;
      mode         <= 1'b0;
      dmaen        <= 1'b0;
      dmamod       <= 1'b0;
      dtwe         <= 1'b0;
      mod_pend     <= 1'b0;
      mod_pend_val <= 1'b0;
    end else if (reg_wr) begin
      autoset  <= reg_wdata[B_AUTO];
      mode     <= reg_wdata[B_MODE];
      dmaen    <= reg_wdata[B_DMAEN];
      dtwe     <= reg_wdata[B_DTWE];
      mod_pend <= 1'b0;
      if (!dmaen) begin
        dmamod <= reg_wdata[B_DMAMOD];
      end else if (!reg_wdata[B_DMAEN]) begin
        // request is being dropped: apply the mode once it is low
        mod_pend     <= 1'b1;
        mod_pend_val <= reg_wdata[B_DMAMOD];
      end
    end else begin
      dtwe <= 1'b0;
      if (mod_pend) begin
        dmamod   <= mod_pend_val;
        mod_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txep_pkt_state.sv
module txep_pkt_state
  import usb_txep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic ack,
  input  logic force_req,
  input  logic dt_load,
  input  logic dt_wval,
  output logic txrdy,
  output logic dt,
  output logic fifo_flush,
  output logic evt_toggle
);
  logic ack_hit;
  logic force_hit;

  assign ack_hit    = ack & txrdy;
  assign force_hit  = force_req & txrdy;
  assign evt_toggle = ack_hit | force_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txrdy      <= 1'b0;
      dt         <= 1'b0;
      fifo_flush <= 1'b0;
    end else begin
      dt         <= dt_next(dt_load, dt_wval, evt_toggle, dt);
      fifo_flush <= evt_toggle;
      if (evt_toggle)   txrdy <= 1'b0;
      else if (set_req) txrdy <= 1'b1;
    end
  end
endmodule

// File: rtl/txep_dma_irq.sv
module txep_dma_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic dmaen,
  input  logic dmamod,
  input  logic txrdy,
  input  logic tx_dir,
  input  logic dma_pkt_done,
  input  logic dma_xfer_done,
  output logic dma_req,
  output logic ep_irq
);
  logic irq_evt;

  assign dma_req = dmaen & ~txrdy & tx_dir;
  assign irq_evt = dmaen & (dmamod ? dma_xfer_done : dma_pkt_done);

  always_ff @(posedge clk) begin
    if (!rst_n) ep_irq <= 1'b0;
    else        ep_irq <= irq_evt;
  end
endmodule

// File: rtl/usb_tx_ep_ctrl.sv
module usb_tx_ep_ctrl
  import usb_txep_pkg::*;
#(
  parameter int CNT_W       = 7,
  parameter bit SHARED_FIFO = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             txrdy_set,
  input  logic             fifo_wr,
  input  logic [CNT_W-1:0] fifo_level,
  input  logic [CNT_W-1:0] max_pkt,
  input  logic             tx_ack,
  input  logic             dma_pkt_done,
  input  logic             dma_xfer_done,
  output logic             txrdy,
  output logic             data_toggle,
  output logic             fifo_flush,
  output logic             dma_req,
  output logic             ep_irq,
  output logic             dir_tx
);
  localparam int CW = (CNT_W > 16) ? 16 : CNT_W;

  logic autoset, mode, dmaen, dmamod, dtwe;
  logic evt_dt_load, dt_wval, force_req;
  logic evt_auto_set, evt_toggle, set_req;

  txep_cfg_reg i_cfg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .autoset(autoset), .mode(mode), .dmaen(dmaen), .dmamod(dmamod),
    .dtwe(dtwe), .dt_load(evt_dt_load), .dt_wval(dt_wval), .force_req(force_req)
  );

  generate
    if (SHARED_FIFO) begin : g_shared
      assign dir_tx = mode;
    end else begin : g_dedicated
      logic mode_unused;
      assign mode_unused = mode;
      assign dir_tx = 1'b1;
    end
  endgenerate

  assign evt_auto_set = fifo_wr & autoset & dir_tx &
                        pkt_full(16'(fifo_level[CW-1:0]), 16'(max_pkt[CW-1:0]));
  assign set_req = txrdy_set | evt_auto_set;

  txep_pkt_state i_pkt (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .ack(tx_ack),
    .force_req(force_req), .dt_load(evt_dt_load), .dt_wval(dt_wval),
    .txrdy(txrdy), .dt(data_toggle), .fifo_flush(fifo_flush),
    .evt_toggle(evt_toggle)
  );

  txep_dma_irq i_dma (
    .clk(clk), .rst_n(rst_n), .dmaen(dmaen), .dmamod(dmamod),
    .txrdy(txrdy), .tx_dir(dir_tx), .dma_pkt_done(dma_pkt_done),
    .dma_xfer_done(dma_xfer_done), .dma_req(dma_req), .ep_irq(ep_irq)
  );

  always_comb begin
    reg_rdata           = 8'h00;
    reg_rdata[B_AUTO]   = autoset;
    reg_rdata[B_MODE]   = mode;
    reg_rdata[B_DMAEN]  = dmaen;
    reg_rdata[B_DMAMOD] = dmamod;
    reg_rdata[B_DTWE]   = dtwe;
    reg_rdata[B_DT]     = data_toggle;
  end
endmodule

// File: rtl/usb_tx_ep_ctrl_chk.sv
module usb_tx_ep_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_rdata,
  input logic       reg_wr,
  input logic       txrdy,
  input logic       data_toggle,
  input logic       fifo_flush,
  input logic       dma_req,
  input logic       ep_irq,
  input logic       evt_dt_load,
  input logic       evt_toggle,
  input logic       evt_auto_set
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6] == 1'b0 && reg_rdata[3] == 1'b0);

  a_r3_auto_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_auto_set && !evt_toggle) |=> txrdy);

  a_r5_dtwe_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1] && !reg_wr) |=> !reg_rdata[1]);

  a_r5_dt_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_toggle) |-> $past(evt_dt_load || evt_toggle));

  a_r7_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> !fifo_flush);

  a_r7_flush_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> !txrdy);

  a_r8_req_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (!txrdy && reg_rdata[4]));

  a_r9_irq_needs_dma: assert property (@(posedge clk) disable iff (!rst_n)
    ep_irq |-> $past(reg_rdata[4]));

  a_r10_mode_under_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_rdata[2]) |-> !$past(reg_rdata[4]));
endmodule

bind usb_tx_ep_ctrl usb_tx_ep_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .reg_wr(reg_wr),
  .txrdy(txrdy), .data_toggle(data_toggle), .fifo_flush(fifo_flush),
  .dma_req(dma_req), .ep_irq(ep_irq), .evt_dt_load(evt_dt_load),
  .evt_toggle(evt_toggle), .evt_auto_set(evt_auto_set)
);

// File: tb/test_usb_tx_ep_ctrl.sv
module test_usb_tx_ep_ctrl;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic txrdy_set = 1'b0, fifo_wr = 1'b0, tx_ack = 1'b0;
  logic dma_pkt_done = 1'b0, dma_xfer_done = 1'b0;
  logic [CW-1:0] fifo_level = '0, max_pkt = '0;
  logic txrdy, data_toggle, fifo_flush, dma_req, ep_irq, dir_tx;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic exp_dt = 1'b0;

  always #10 clk = ~clk;

  usb_tx_ep_ctrl #(.CNT_W(CW), .SHARED_FIFO(1'b1)) i_usb_tx_ep_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .txrdy_set(txrdy_set), .fifo_wr(fifo_wr),
    .fifo_level(fifo_level), .max_pkt(max_pkt), .tx_ack(tx_ack),
    .dma_pkt_done(dma_pkt_done), .dma_xfer_done(dma_xfer_done),
    .txrdy(txrdy), .data_toggle(data_toggle), .fifo_flush(fifo_flush),
    .dma_req(dma_req), .ep_irq(ep_irq), .dir_tx(dir_tx)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1;
    reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic set_rdy();
    txrdy_set = 1'b1;
    tick();
    txrdy_set = 1'b0;
  endtask

  task automatic ack();
    tx_ack = 1'b1;
    tick();
    tx_ack = 1'b0;
  endtask

  task automatic fifo_push(input int lvl, input int mx);
    fifo_level = CW'(lvl);
    max_pkt = CW'(mx);
    fifo_wr = 1'b1;
    tick();
    fifo_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 outputs", {2'b0, txrdy, data_toggle, fifo_flush, dma_req, ep_irq, dir_tx}, 8'h00);

    // R2 layout, R5 toggle load and self-clear, R10 deferred mode
    wr(8'hFF); exp_dt = 1'b1;
    chk("R2 layout all", reg_rdata, 8'hB7);
    tick();
    chk("R5 dtwe self clear", reg_rdata, 8'hB5);
    wr(8'h00);
    chk("R10 mode held while enable drops", reg_rdata, 8'h05);
    tick();
    chk("R10 mode applied after", reg_rdata, 8'h01);
    wr(8'h01);
    chk("R5 dt needs dtwe", reg_rdata, 8'h01);
    wr(8'h02); exp_dt = 1'b0;
    chk("R5 dt load 0", reg_rdata, 8'h02);
    wr(8'h14);
    chk("R10 mode with enable from idle", reg_rdata, 8'h14);
    wr(8'h10);
    chk("R10 mode kept under enable", reg_rdata, 8'h14);
    wr(8'h00); tick();
    chk("R10 mode cleared later", reg_rdata, 8'h00);

    // R8 DMA request, R4 software set, R7 ack
    wr(8'h30);
    chk("R8 req idle", {7'b0, dma_req}, 8'h01);
    chk("R11 dir tx", {7'b0, dir_tx}, 8'h01);
    set_rdy();
    chk("R4 sw set", {7'b0, txrdy}, 8'h01);
    chk("R8 req off when ready", {7'b0, dma_req}, 8'h00);
    ack(); exp_dt = ~exp_dt;
    chk("R7 ack clears ready", {7'b0, txrdy}, 8'h00);
    chk("R7 ack toggles", {7'b0, data_toggle}, {7'b0, exp_dt});
    chk("R7 flush pulse", {7'b0, fifo_flush}, 8'h01);
    tick();
    chk("R7 flush one cycle", {7'b0, fifo_flush}, 8'h00);
    ack();
    chk("R7 ack idle ignored dt", {7'b0, data_toggle}, {7'b0, exp_dt});
    chk("R7 ack idle no flush", {7'b0, fifo_flush}, 8'h00);
    wr(8'h10);
    chk("R11 rx dir no req", {6'b0, dir_tx, dma_req}, 8'h00);

    // R9 interrupt modes
    wr(8'h30);
    dma_pkt_done = 1'b1; tick(); dma_pkt_done = 1'b0;
    chk("R9 per packet irq", {7'b0, ep_irq}, 8'h01);
    tick();
    chk("R9 irq one cycle", {7'b0, ep_irq}, 8'h00);
    dma_xfer_done = 1'b1; tick(); dma_xfer_done = 1'b0;
    chk("R9 xfer ignored in packet mode", {7'b0, ep_irq}, 8'h00);
    wr(8'h20); wr(8'h34);
    dma_pkt_done = 1'b1; tick(); dma_pkt_done = 1'b0;
    chk("R9 packet ignored in xfer mode", {7'b0, ep_irq}, 8'h00);
    dma_xfer_done = 1'b1; tick(); dma_xfer_done = 1'b0;
    chk("R9 per transfer irq", {7'b0, ep_irq}, 8'h01);
    wr(8'h24);
    dma_xfer_done = 1'b1; dma_pkt_done = 1'b1; tick();
    dma_xfer_done = 1'b0; dma_pkt_done = 1'b0;
    chk("R9 no irq when disabled", {7'b0, ep_irq}, 8'h00);

    // R6 force toggle
    wr(8'h20);
    set_rdy();
    wr(8'h28); exp_dt = ~exp_dt;
    chk("R6 force toggles", {7'b0, data_toggle}, {7'b0, exp_dt});
    chk("R6 force clears ready", {7'b0, txrdy}, 8'h00);
    chk("R6 force flush", {7'b0, fifo_flush}, 8'h01);
    chk("R2 force bit reads 0", reg_rdata & 8'h48, 8'h00);
    tick();
    wr(8'h28);
    chk("R6 force idle ignored dt", {7'b0, data_toggle}, {7'b0, exp_dt});
    chk("R6 force idle no flush", {7'b0, fifo_flush}, 8'h00);

    // R12 load beats toggle
    set_rdy();
    wr({7'b0010101, exp_dt});
    chk("R12 load wins", {7'b0, data_toggle}, {7'b0, exp_dt});
    chk("R12 ready cleared", {7'b0, txrdy}, 8'h00);
    tick();

    // R3 sweep over every max size and level
    wr(8'hA0);
    for (int m = 1; m < 16; m++) begin
      for (int l = 0; l < 16; l++) begin
        fifo_push(l, m);
        chk($sformatf("R3 auto m=%0d l=%0d", m, l), {7'b0, txrdy}, {7'b0, l == m});
        if (txrdy) begin
          ack(); exp_dt = ~exp_dt;
          chk("R7 ack after auto", {7'b0, data_toggle}, {7'b0, exp_dt});
        end
      end
    end
    fifo_push(0, 0);
    chk("R3 zero max never sets", {7'b0, txrdy}, 8'h00);

    // R11 rx direction blocks auto-set; R4 auto-set off
    wr(8'h80);
    for (int m = 1; m < 16; m++) begin
      fifo_push(m, m);
      chk($sformatf("R11 rx no auto m=%0d", m), {7'b0, txrdy}, 8'h00);
    end
    wr(8'h20);
    for (int m = 1; m < 16; m++) begin
      fifo_push(m, m);
      chk($sformatf("R4 no auto m=%0d", m), {7'b0, txrdy}, 8'h00);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule